// File: doc/BRIEF.md
# Periodic interrupt down-counter timer

A 32-bit timer that counts down by one on each prescaled tick and raises a compare flag and a level interrupt. Three tick-enable inputs stand for three clock sources. A two-bit field in the control word picks one of them, or none. A 12-bit prescaler then divides the picked source by its field value plus one. When the count reaches zero, the counter either reloads from the load register (reload mode) or wraps to all ones (free-run mode).

Software reaches the timer through a word-indexed write port and a combinational read port. Besides the control word there are a status flag, a load value, a compare value and a read-only current count. An overwrite bit makes a load write go straight into the counter. A self-clearing soft-reset bit returns the timer to its power-up values but keeps the enable bit and the low-power enable bits of the written word.

Top module: `pit_down_timer`

## Requirements
- R1: Word index 0 is control, 1 is status (flag in bit 0), 2 is load, 3 is compare and 4 is the current count. A write to index 4 or to an index from 5 to 7 changes nothing, and indices 5 to 7 read as zero.
- R2: Control bits 25:24 select the tick source: 00 gives no ticks, 01 `tick_periph`, 10 `tick_fast` and 11 `tick_slow`.
- R3: Control bits 15:4 hold a prescale value P. The counter moves once every P+1 source ticks. A new P takes effect only after the prescaler's current period ends. An enable rise restarts the prescaler with the written P.
- R4: A control write stores bits 25:0 of the data, and control reads return them zero-extended.
- R5: Writing control with bit 16 set performs a soft reset. Control keeps only bits 0, 1, 18, 19, 20 and 21 of the written data. Status and compare clear, and load and count become 0xFFFFFFFF.
- R6: When control bit 0 (enable) goes from 0 to 1 with bit 1 (enable mode) set, the count loads from the load register if bit 3 (reload mode) is set, and from 0xFFFFFFFF otherwise. With bit 1 clear, the count keeps its value.
- R7: While enabled, each prescaled tick decrements the count. From zero it moves to the load value in reload mode and to 0xFFFFFFFF in free-run mode.
- R8: A load write with control bit 17 set puts the data into the count in that same cycle, in place of any tick. With bit 17 clear, the count is left alone.
- R9: The status flag sets when a tick moves the count onto the compare value. Writing status with bit 0 set clears the flag, and a set in the same cycle wins.
- R10: `irq` is high exactly while the flag, control bit 2 (compare interrupt enable) and control bit 0 are all set.
- R11: With control bit 0 clear, the count holds its value.
- R12: After the asynchronous reset, control, status and compare read 0, and load and count read 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_periph | input | 1 | Tick enable of source 01 |
| tick_fast | input | 1 | Tick enable of source 10 |
| tick_slow | input | 1 | Tick enable of source 11 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word index for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A wrong prescaler phase or a wrong divider value shows up only as a count that moves a cycle early or late. Reading the count every cycle catches it at the first tick after the fault. A wrong reload or wrap choice shows at the first pass through zero. A compare flag set on the wrong condition reaches `irq` in the same cycle the flag is stored. Soft-reset and overwrite faults appear on the read port one cycle after the offending write, which is when the bench compares against its model.

// File: rtl/pit_down_timer.sv
module pit_down_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_periph,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);

  localparam int CTRL_W  = 26;
  localparam int PSC_W   = 12;
  localparam int B_EN    = 0;
  localparam int B_ENMOD = 1;
  localparam int B_OCIE  = 2;
  localparam int B_RLD   = 3;
  localparam int B_PSC   = 4;
  localparam int B_SRST  = 16;
  localparam int B_OVW   = 17;
  localparam int B_SRC   = 24;
  localparam logic [CTRL_W-1:0] KEEP = CTRL_W'(32'h003C_0003);
  localparam logic [CNT_W-1:0]  MAXV = '1;

  logic [CTRL_W-1:0] ctrl;
  logic              flag;
  logic [CNT_W-1:0]  ld, cmpv, cnt;
  logic [PSC_W-1:0]  pcnt, pdiv;
  logic              src_tick;

  wire [CTRL_W-1:0] wctrl  = wdata[CTRL_W-1:0];
  wire wr_ctrl = wr_en && addr == 3'd0;
  wire wr_stat = wr_en && addr == 3'd1;
  wire wr_ld   = wr_en && addr == 3'd2;
  wire wr_cmp  = wr_en && addr == 3'd3;
  wire srst    = wr_ctrl && wctrl[B_SRST];
  wire en_rise = wr_ctrl && !srst && wctrl[B_EN] && !ctrl[B_EN];
  wire ovw     = wr_ld && ctrl[B_OVW];

  always_comb begin
    unique case (ctrl[B_SRC+:2])
      2'b01:   src_tick = tick_periph;
      2'b10:   src_tick = tick_fast;
      2'b11:   src_tick = tick_slow;
      default: src_tick = 1'b0;
    endcase
  end

  wire run      = ctrl[B_EN] && src_tick;
  wire pre_hit  = run && pcnt == pdiv;
  wire tick_upd = pre_hit && !srst && !ovw;
  wire [CNT_W-1:0] nxt = (cnt == '0) ? (ctrl[B_RLD] ? ld : MAXV) : cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      pdiv <= '0;
    end else if (srst) begin
      pcnt <= '0;
      pdiv <= '0;
    end else if (en_rise) begin
      pcnt <= '0;
      pdiv <= wctrl[B_PSC+:PSC_W];
    end else if (pre_hit) begin
      pcnt <= '0;
      pdiv <= ctrl[B_PSC+:PSC_W];
    end else if (run) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      ld   <= MAXV;
      cmpv <= '0;
    end else if (srst) begin
      ctrl <= wctrl & KEEP;
      ld   <= MAXV;
      cmpv <= '0;
    end else begin
      if (wr_ctrl) ctrl <= wctrl;
      if (wr_ld)   ld   <= wdata;
      if (wr_cmp)  cmpv <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= MAXV;
    else if (srst)                             cnt <= MAXV;
    else if (ovw)                              cnt <= wdata;
    else if (en_rise && wctrl[B_ENMOD])        cnt <= wctrl[B_RLD] ? ld : MAXV;
    else if (tick_upd)                         cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag <= 1'b0;
    else if (srst)                     flag <= 1'b0;
    else if (tick_upd && nxt == cmpv)  flag <= 1'b1;
    else if (wr_stat && wdata[0])      flag <= 1'b0;
  end

  assign irq = flag && ctrl[B_OCIE] && ctrl[B_EN];

  always_comb begin
    case (addr)
      3'd0:    rdata = CNT_W'(ctrl);
      3'd1:    rdata = CNT_W'(flag);
      3'd2:    rdata = ld;
      3'd3:    rdata = cmpv;
      3'd4:    rdata = cnt;
      default: rdata = '0;
    endcase
  end

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cnt == MAXV && ld == MAXV && cmpv == '0 && !flag)); // R5
  AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ovw |=> cnt == $past(wdata)); // R8
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_hit && cnt != '0 && !(wr_en && (addr == 3'd0 || addr == 3'd2))) |=> cnt == $past(cnt) - 1'b1); // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[B_EN] && !(wr_en && (addr == 3'd0 || addr == 3'd2))) |=> $stable(cnt)); // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[0] && !pre_hit) |=> !flag); // R9
  AST_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= 3'd4) |=> ($stable(cmpv) && $stable(ld) && $stable(ctrl))); // R1

endmodule

// File: tb/test_pit_down_timer.sv
module test_pit_down_timer;
  localparam int TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_periph = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0, cyc = 0;

  pit_down_timer i_pit_down_timer (
    .clk(clk), .rst_n(rst_n), .tick_periph(tick_periph), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  always #(TCLK/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    tick_periph = 1'b1;
    tick_fast   = cyc[0];
    tick_slow   = (cyc % 8) == 0;
  end

  // behavioural reference model
  logic [31:0] m_ctrl, m_ld, m_cmp, m_cnt;
  logic m_flag;
  int m_pc, m_pd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ld = 32'hFFFF_FFFF; m_cmp = 0; m_cnt = 32'hFFFF_FFFF;
      m_flag = 0; m_pc = 0; m_pd = 0;
    end else begin
      logic [31:0] c, n_ctrl, n_ld, n_cmp, n_cnt, v;
      logic n_flag, src, hit;
      int n_pc, n_pd;
      c = m_ctrl; n_ctrl = m_ctrl; n_ld = m_ld; n_cmp = m_cmp; n_cnt = m_cnt;
      n_flag = m_flag; n_pc = m_pc; n_pd = m_pd;
      case (c[25:24])
        2'd1: src = tick_periph;
        2'd2: src = tick_fast;
        2'd3: src = tick_slow;
        default: src = 0;
      endcase
      hit = c[0] && src && (m_pc == m_pd);
      if (c[0] && src) begin
        if (hit) begin n_pc = 0; n_pd = int'(c[15:4]); end
        else n_pc = m_pc + 1;
      end
      if (wr_en && addr == 1 && wdata[0]) n_flag = 0;
      if (hit && !(wr_en && addr == 2 && c[17])) begin
        if (m_cnt == 0) v = c[3] ? m_ld : 32'hFFFF_FFFF;
        else v = m_cnt - 1;
        n_cnt = v;
        if (v == m_cmp) n_flag = 1;
      end
      if (wr_en) begin
        case (addr)
          3'd0: if (wdata[16]) begin
                  n_ctrl = wdata & 32'h003C_0003; n_flag = 0; n_cmp = 0;
                  n_ld = 32'hFFFF_FFFF; n_cnt = 32'hFFFF_FFFF; n_pc = 0; n_pd = 0;
                end else begin
                  n_ctrl = wdata & 32'h03FF_FFFF;
                  if (wdata[0] && !c[0]) begin
                    n_pc = 0; n_pd = int'(wdata[15:4]);
                    if (wdata[1]) n_cnt = wdata[3] ? m_ld : 32'hFFFF_FFFF;
                  end
                end
          3'd2: begin n_ld = wdata; if (c[17]) n_cnt = wdata; end
          3'd3: n_cmp = wdata;
          default: ;
        endcase
      end
      m_ctrl = n_ctrl; m_ld = n_ld; m_cmp = n_cmp; m_cnt = n_cnt;
      m_flag = n_flag; m_pc = n_pc; m_pd = n_pd;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return {31'd0, m_flag};
      3'd2: return m_ld;
      3'd3: return m_cmp;
      3'd4: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1: return "R9";
      3'd2: return "R8";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R1";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      n_chk++;
      if (rdata !== m_read(addr)) begin
        n_fail++;
        $display("FAIL %s idx %0d: got %h expected %h", tag_of(addr), addr, rdata, m_read(addr));
      end
      n_chk++;
      if (irq !== (m_flag && m_ctrl[2] && m_ctrl[0])) begin
        n_fail++;
        $display("FAIL R10 irq: got %b expected %b", irq, m_flag && m_ctrl[2] && m_ctrl[0]);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s idx %0d: got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 power-up values
    chk(0, 0, "R12"); chk(1, 0, "R12"); chk(2, 32'hFFFF_FFFF, "R12");
    chk(3, 0, "R12"); chk(4, 32'hFFFF_FFFF, "R12"); chk_irq(0, "R12");
    // R4 only the low 26 bits are kept
    wr(0, 32'hFFFE_FFFF); chk(0, 32'h03FE_FFFF, "R4");
    wr(0, 0);
    // R8 overwrite off, then on
    rd(4, v);
    wr(2, 100); chk(4, v, "R8"); chk(2, 100, "R8");
    wr(0, 32'h0002_0000); wr(2, 50); chk(4, 50, "R8");
    // R6 / R7 reload mode
    wr(0, 0); wr(2, 50); wr(0, 32'h0100_000B); chk(4, 50, "R6");
    cycles(3); chk(4, 47, "R7");
    wr(0, 0); wr(2, 3); wr(0, 32'h0100_000B); chk(4, 3, "R6");
    cycles(3); chk(4, 0, "R7"); cycles(1); chk(4, 3, "R7");
    // free run
    wr(0, 0); wr(0, 32'h0100_0003); chk(4, 32'hFFFF_FFFF, "R6");
    cycles(1); chk(4, 32'hFFFF_FFFE, "R7");
    wr(0, 32'h0102_0003); wr(2, 1); chk(4, 1, "R8");
    cycles(1); chk(4, 0, "R7"); cycles(1); chk(4, 32'hFFFF_FFFF, "R7");
    // R3 prescaler divide by 4, then change to 2 at next terminal
    wr(0, 32'h0002_0000); wr(2, 100); wr(0, 32'h0102_0031); chk(4, 100, "R6");
    cycles(3); chk(4, 100, "R3"); cycles(1); chk(4, 99, "R3");
    cycles(4); chk(4, 98, "R3");
    wr(0, 32'h0102_0011);
    cycles(2); chk(4, 98, "R3"); cycles(1); chk(4, 97, "R3");
    cycles(2); chk(4, 96, "R3");
    // R2 source selection
    wr(0, 32'h0002_0000); wr(2, 100); wr(0, 32'h0302_0001);
    rd(4, v); cycles(16); chk(4, v - 2, "R2");
    wr(0, 32'h0002_0000); wr(0, 32'h0202_0001);
    rd(4, v); cycles(16); chk(4, v - 8, "R2");
    wr(0, 32'h0002_0000); wr(0, 32'h0002_0001);
    rd(4, v); cycles(16); chk(4, v, "R2");
    // R9 / R10 compare flag and interrupt gating
    wr(0, 32'h0002_0000); wr(3, 3); wr(2, 5); wr(1, 1); wr(0, 32'h0102_0001);
    cycles(1); chk(1, 0, "R9");
    cycles(1); chk(1, 1, "R9"); chk(4, 3, "R9"); chk_irq(0, "R10");
    wr(0, 32'h0102_0005); chk_irq(1, "R10");
    wr(1, 1); chk(1, 0, "R9"); chk_irq(0, "R10");
    wr(0, 32'h0002_0004); wr(2, 9); wr(3, 8); wr(0, 32'h0102_0005);
    cycles(1); chk(1, 1, "R9"); chk_irq(1, "R10");
    wr(0, 32'h0002_0004); chk_irq(0, "R10"); chk(1, 1, "R10");
    // R11 hold while disabled
    rd(4, v); cycles(5); chk(4, v, "R11");
    // R5 soft reset
    wr(0, 32'h0124_005F); wr(3, 77); wr(0, 32'h0125_005F);
    chk(0, 32'h0024_0003, "R5"); chk(1, 0, "R5"); chk(2, 32'hFFFF_FFFF, "R5");
    chk(3, 0, "R5"); chk(4, 32'hFFFF_FFFF, "R5");
    cycles(4); chk(4, 32'hFFFF_FFFF, "R5");
    // R1 ignored indices
    wr(4, 5); chk(4, 32'hFFFF_FFFF, "R1");
    wr(6, 123); chk(6, 0, "R1"); chk(5, 0, "R1"); chk(7, 0, "R1");
    chk(2, 32'hFFFF_FFFF, "R1"); chk(3, 0, "R1");
    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      if (r == 0 && ($urandom % 8) == 0) wr(0, $urandom | 32'h0001_0000);
      else if (r < 3) begin
        logic [31:0] c;
        c = $urandom & 32'hFFFE_FF0F;
        c[15:4] = 12'($urandom % 4);
        wr(0, c);
      end
      else if (r < 5) wr(2, $urandom % 20);
      else if (r < 6) wr(3, $urandom % 20);
      else if (r < 7) wr(1, $urandom);
      else if (r < 8) wr(3'($urandom), $urandom);
      else begin addr = 3'($urandom); cycles(1); end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule